// File: doc/BRIEF.md
# Memory-mapped 64-bit machine timer

This peripheral keeps a free-running 64-bit time value and a 64-bit compare value. Software reaches both through four 32-bit words on a simple register bus. The bus has a word address, a write strobe, a read strobe, write data and read data, and every access completes in one cycle. The time value advances by one on each cycle in which the tick enable input is high. A system with a 1 GHz time base drives that input so that one tick equals one nanosecond.

Software sets the compare value in two steps. It writes the low compare word first, then the high compare word. Only the write to the high word arms the comparator. When an armed comparator sees the time value equal to the compare value, the block raises its interrupt output. The output stays high for a fixed number of ticks, and the comparator disarms at the same moment. The next interrupt needs a new write to the high compare word.

A 64-bit time value cannot be read in one 32-bit access. A read of the low time word therefore also captures the upper half into a snapshot register, and the next read of the high time word returns that snapshot. The two halves then come from the same instant.

Top module: `mach_timer`

## Requirements
- R1: After reset, the time value, the compare value and the arm flag are zero, the interrupt output is low, and all four words read as zero.
- R2: The time value increases by exactly one on every clock edge at which `tickEn` is high and no time word is written in that cycle. It holds its value when `tickEn` is low.
- R3: A write to byte offset 0x0 replaces bits 31:0 of the time value, and a write to offset 0x4 replaces bits 63:32. The other half keeps its value. In the cycle of such a write the tick does not advance the time value.
- R4: A read at offset 0x8 returns bits 31:0 of the stored compare value, and a read at offset 0xC returns bits 63:32.
- R5: A write to offset 0x8 alone does not arm the comparator. The time value can pass the compare value without raising the interrupt.
- R6: A write to offset 0xC arms the comparator. The interrupt output rises on the clock edge that follows a cycle in which the comparator is armed and the time value equals the compare value.
- R7: The interrupt output stays high for exactly `PULSE_TICKS` cycles with `tickEn` high (20 by default). It falls at the edge of the last of those cycles. Cycles without a tick do not shorten the pulse.
- R8: The arm flag clears when the interrupt fires. If the time value later equals the same compare value again, no interrupt is raised unless offset 0xC is written again.
- R9: Read data is combinational in `regAddr`. A read at offset 0x0 (with `regRe` high) returns the live low half and captures the upper half of the time value into a snapshot. A read at offset 0x4 returns that snapshot, not the live upper half.
- R10: A read at any offset other than 0x0, 0x4, 0x8 and 0xC returns zero, and a write to such an offset changes no register.
- R11: The time value wraps from all ones to zero on a tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| tickEn | input | 1 | One-cycle tick; advances the time value |
| regAddr | input | ADDR_W | Byte address of the register word |
| regWe | input | 1 | Write strobe |
| regRe | input | 1 | Read strobe (captures the snapshot at offset 0x0) |
| regWdata | input | WORD_W | Write data |
| regRdata | output | WORD_W | Read data for `regAddr`, combinational |
| irqOut | output | 1 | Timer interrupt pulse |

## Verification
A wrong arm flag shows up at the ports only at the next match. That match may lie many ticks after the fault, so the bench runs the time value through the compare value both with and without a preceding write to 0xC. A corrupted pulse counter shows up when `irqOut` falls early or late. The reference model flags this on the exact cycle, because it compares `irqOut` and `regRdata` on every clock. A stale or torn snapshot shows up on the first read at offset 0x4 after a carry into the upper half.

// File: rtl/mach_timer_pkg.sv
package mach_timer_pkg;

  // Word index taken from byte address bits 3:2
  typedef enum logic [1:0] {
    SEL_CNT_LO = 2'd0,
    SEL_CNT_HI = 2'd1,
    SEL_CMP_LO = 2'd2,
    SEL_CMP_HI = 2'd3
  } wordSel_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic wrCntLo;
    logic wrCntHi;
    logic wrCmpLo;
    logic wrCmpHi;
    logic snapCnt;
  } timerStrobes_t;

endpackage

// File: rtl/mach_timer_ctrl.sv
module mach_timer_ctrl
  import mach_timer_pkg::*;
#(
  parameter int ADDR_W      = 6,
  parameter int PULSE_TICKS = 20
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWe,
  input  logic              regRe,
  input  logic              eqHit,
  output timerStrobes_t     strobes,
  output wordSel_e          wordSel,
  output logic              selValid,
  output logic              armed,
  output logic              irqOut
);

  localparam int PW = $clog2(PULSE_TICKS + 1);

  logic [PW-1:0] pulseCnt;
  logic          fire;
  logic          wrOk;

  // Address decode: word aligned, inside the 16-byte window
  assign wordSel  = wordSel_e'(regAddr[3:2]);
  assign selValid = ((regAddr >> 4) == '0) && (regAddr[1:0] == 2'b00);
  assign wrOk     = regWe && selValid;

  always_comb begin
    strobes         = '0;
    strobes.wrCntLo = wrOk && (wordSel == SEL_CNT_LO);
    strobes.wrCntHi = wrOk && (wordSel == SEL_CNT_HI);
    strobes.wrCmpLo = wrOk && (wordSel == SEL_CMP_LO);
    strobes.wrCmpHi = wrOk && (wordSel == SEL_CMP_HI);
    strobes.snapCnt = regRe && selValid && (wordSel == SEL_CNT_LO);
  end

  assign fire = armed && eqHit;

  // Arm on high compare write; disarm when the match fires
  always_ff @(posedge clk) begin
    if (!rstN)                armed <= 1'b0;
    else if (strobes.wrCmpHi) armed <= 1'b1;
    else if (fire)            armed <= 1'b0;
  end

  // Fixed-width pulse measured in ticks
  always_ff @(posedge clk) begin
    if (!rstN) begin
      irqOut   <= 1'b0;
      pulseCnt <= '0;
    end else if (fire) begin
      irqOut   <= 1'b1;
      pulseCnt <= PW'(PULSE_TICKS);
    end else if (irqOut && tickEn) begin
      pulseCnt <= pulseCnt - PW'(1);
      if (pulseCnt == PW'(1)) irqOut <= 1'b0;
    end
  end

endmodule

// File: rtl/mach_timer_dp.sv
module mach_timer_dp
  import mach_timer_pkg::*;
#(
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickEn,
  input  timerStrobes_t     strobes,
  input  wordSel_e          wordSel,
  input  logic              selValid,
  input  logic [WORD_W-1:0] wdata,
  output logic [WORD_W-1:0] rdata,
  output logic              eqHit
);

  localparam int TIME_W = 2 * WORD_W;

  logic [TIME_W-1:0] cntQ;
  logic [TIME_W-1:0] cmpQ;
  logic [WORD_W-1:0] shadowHiQ;

  // Time value: a write to a half wins over the tick
  always_ff @(posedge clk) begin
    if (!rstN)                cntQ <= '0;
    else if (strobes.wrCntLo) cntQ[WORD_W-1:0] <= wdata;
    else if (strobes.wrCntHi) cntQ[TIME_W-1:WORD_W] <= wdata;
    else if (tickEn)          cntQ <= cntQ + TIME_W'(1);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cmpQ <= '0;
    end else begin
      if (strobes.wrCmpLo) cmpQ[WORD_W-1:0]      <= wdata;
      if (strobes.wrCmpHi) cmpQ[TIME_W-1:WORD_W] <= wdata;
    end
  end

  // Upper half captured with a low-word read
  always_ff @(posedge clk) begin
    if (!rstN)                shadowHiQ <= '0;
    else if (strobes.snapCnt) shadowHiQ <= cntQ[TIME_W-1:WORD_W];
  end

  assign eqHit = (cntQ == cmpQ);

  always_comb begin
    rdata = '0;
    if (selValid) begin
      unique case (wordSel)
        SEL_CNT_LO: rdata = cntQ[WORD_W-1:0];
        SEL_CNT_HI: rdata = shadowHiQ;
        SEL_CMP_LO: rdata = cmpQ[WORD_W-1:0];
        SEL_CMP_HI: rdata = cmpQ[TIME_W-1:WORD_W];
      endcase
    end
  end

endmodule

// File: rtl/mach_timer.sv
module mach_timer
  import mach_timer_pkg::*;
#(
  parameter int ADDR_W      = 6,
  parameter int WORD_W      = 32,
  parameter int PULSE_TICKS = 20
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWe,
  input  logic              regRe,
  input  logic [WORD_W-1:0] regWdata,
  output logic [WORD_W-1:0] regRdata,
  output logic              irqOut
);

  timerStrobes_t strobes;
  wordSel_e      wordSel;
  logic          selValid;
  logic          armed;
  logic          eqHit;

  mach_timer_ctrl #(
    .ADDR_W     (ADDR_W),
    .PULSE_TICKS(PULSE_TICKS)
  ) ctrlI (
    .clk     (clk),
    .rstN    (rstN),
    .tickEn  (tickEn),
    .regAddr (regAddr),
    .regWe   (regWe),
    .regRe   (regRe),
    .eqHit   (eqHit),
    .strobes (strobes),
    .wordSel (wordSel),
    .selValid(selValid),
    .armed   (armed),
    .irqOut  (irqOut)
  );

  mach_timer_dp #(
    .WORD_W(WORD_W)
  ) dpI (
    .clk     (clk),
    .rstN    (rstN),
    .tickEn  (tickEn),
    .strobes (strobes),
    .wordSel (wordSel),
    .selValid(selValid),
    .wdata   (regWdata),
    .rdata   (regRdata),
    .eqHit   (eqHit)
  );

endmodule

// File: rtl/mach_timer_chk.sv
module mach_timer_chk #(
  parameter int ADDR_W = 6,
  parameter int WORD_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              tickEn,
  input logic [ADDR_W-1:0] regAddr,
  input logic              regWe,
  input logic [WORD_W-1:0] regRdata,
  input logic              irqOut,
  input logic              armed,
  input logic              eqHit,
  input logic              selValid
);

  // R6
  irq_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irqOut) |-> $past(armed && eqHit));

  // R7
  irq_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (irqOut && !tickEn) |=> irqOut);

  // R8
  disarm_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(armed) |-> irqOut);

  // R2
  tick_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((tickEn && !regWe && regAddr == '0) ##1 (regAddr == '0))
      |-> (regRdata == $past(regRdata) + WORD_W'(1)));

  // R10
  unmapped_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    !selValid |-> (regRdata == '0));

endmodule

bind mach_timer mach_timer_chk #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) chkI (.*);

// File: tb/mach_timer_tb_top.sv
module mach_timer_tb_top;

  localparam int ADDR_W = 6;
  localparam int WORD_W = 32;
  localparam int PULSE  = 20;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              tickEn = 1'b0;
  logic [ADDR_W-1:0] regAddr = '0;
  logic              regWe = 1'b0;
  logic              regRe = 1'b0;
  logic [WORD_W-1:0] regWdata = '0;
  logic [WORD_W-1:0] regRdata;
  logic              irqOut;

  int    checks = 0;
  int    failures = 0;
  string curReq = "R1";
  bit    finished = 0;

  // Behavioural reference state
  longint unsigned mCnt = 0, mCmp = 0, mShadow = 0;
  bit mArmed = 0, mIrq = 0;
  int mRem = 0;

  always #2 clk = ~clk;

  mach_timer #(.ADDR_W(ADDR_W), .WORD_W(WORD_W), .PULSE_TICKS(PULSE)) dut_i (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .regAddr(regAddr),
    .regWe(regWe), .regRe(regRe), .regWdata(regWdata),
    .regRdata(regRdata), .irqOut(irqOut));

  task automatic chk(input string req, input longint unsigned act, input longint unsigned exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=0x%0h exp=0x%0h", req, act, exp);
    end
  endtask

  function automatic longint unsigned modelRead(input int a);
    case (a)
      0:  return mCnt & 64'hFFFF_FFFF;
      4:  return mShadow >> 32;
      8:  return mCmp & 64'hFFFF_FFFF;
      12: return mCmp >> 32;
      default: return 0;
    endcase
  endfunction

  // Apply one clock with the given inputs, update model, compare at negedge
  task automatic step(input bit t, input bit we, input bit re, input int a, input longint unsigned wd);
    bit hit;
    tickEn = t; regWe = we; regRe = re; regAddr = ADDR_W'(a); regWdata = WORD_W'(wd);
    @(posedge clk);
    if (!rstN) begin
      mCnt = 0; mCmp = 0; mShadow = 0; mArmed = 0; mIrq = 0; mRem = 0;
    end else begin
      hit = mArmed && (mCnt == mCmp);
      if (re && a == 0) mShadow = mCnt;
      if (we && a == 0)      mCnt = {mCnt[63:32], wd[31:0]};
      else if (we && a == 4) mCnt = {wd[31:0], mCnt[31:0]};
      else if (t)            mCnt = mCnt + 1;
      if (we && a == 8)  mCmp = {mCmp[63:32], wd[31:0]};
      if (we && a == 12) mCmp = {wd[31:0], mCmp[31:0]};
      if (we && a == 12) mArmed = 1;
      else if (hit)      mArmed = 0;
      if (hit) begin
        mIrq = 1; mRem = PULSE;
      end else if (mIrq && t) begin
        mRem--;
        if (mRem == 0) mIrq = 0;
      end
    end
    @(negedge clk);
    chk({curReq, " irq"}, longint'(irqOut), longint'(mIrq));
    chk({curReq, " rdata"}, longint'(regRdata), modelRead(a));
  endtask

  task automatic idle(input int n, input bit t, input int a);
    for (int i = 0; i < n; i++) step(t, 0, 0, a, 0);
  endtask

  task automatic wr(input int a, input longint unsigned d);
    step(0, 1, 0, a, d);
  endtask

  initial begin
    @(negedge clk);
    idle(3, 1, 0);
    rstN = 1'b1;

    // R1: reset state
    curReq = "R1";
    chk("R1 irq", longint'(irqOut), 0);
    step(0, 0, 1, 0, 0);
    chk("R1 lo", longint'(regRdata), 0);
    for (int a = 4; a <= 12; a += 4) begin
      step(0, 0, 0, a, 0);
      chk("R1 word", longint'(regRdata), 0);
    end

    // R5: low compare write only, time passes it
    curReq = "R5";
    wr(8, 40);
    idle(60, 1, 0);
    chk("R5 no irq", longint'(irqOut), 0);

    // R2: ticking and holding
    curReq = "R2";
    idle(10, 0, 0);
    chk("R2 hold", longint'(regRdata), 60);
    for (int i = 0; i < 12; i++) step(i % 3 != 0, 0, 0, 0, 0);

    // R3: half writes, write beats tick
    curReq = "R3";
    step(1, 1, 0, 0, 32'hFFFF_FFF0);
    chk("R3 lo", longint'(regRdata), 32'hFFFF_FFF0);
    step(1, 1, 0, 4, 32'h0000_0001);
    step(0, 0, 1, 0, 0);
    step(0, 0, 0, 4, 0);
    chk("R3 hi", longint'(regRdata), 1);

    // R9: snapshot stays when upper half moves
    curReq = "R9";
    wr(0, 32'hFFFF_FFFE);
    step(0, 0, 1, 0, 0);
    idle(4, 1, 0);
    step(0, 0, 0, 4, 0);
    chk("R9 snap", longint'(regRdata), 1);
    step(0, 0, 1, 0, 0);
    step(0, 0, 0, 4, 0);
    chk("R9 fresh", longint'(regRdata), 2);

    // R11: wrap
    curReq = "R11";
    wr(0, 32'hFFFF_FFFF);
    wr(4, 32'hFFFF_FFFF);
    idle(2, 1, 0);
    step(0, 0, 1, 0, 0);
    chk("R11 lo", longint'(regRdata), 1);
    step(0, 0, 0, 4, 0);
    chk("R11 hi", longint'(regRdata), 0);

    // R4: compare read back (also arms; time far below)
    curReq = "R4";
    wr(8, 32'h1234_5678);
    wr(12, 32'h0000_00AB);
    step(0, 0, 0, 8, 0);
    chk("R4 lo", longint'(regRdata), 32'h1234_5678);
    step(0, 0, 0, 12, 0);
    chk("R4 hi", longint'(regRdata), 32'hAB);

    // R6 and R7: armed match and pulse width
    curReq = "R6";
    wr(0, 0);
    wr(4, 0);
    wr(8, 30);
    wr(12, 0);
    idle(30, 1, 0);
    chk("R6 before", longint'(irqOut), 0);
    idle(1, 1, 0);
    chk("R6 rise", longint'(irqOut), 1);
    curReq = "R7";
    begin
      int highTicks = 0;
      for (int i = 0; i < 40; i++) begin
        bit t = (i % 4 != 1);
        if (irqOut && t) highTicks++;
        step(t, 0, 0, 0, 0);
      end
      chk("R7 width", longint'(highTicks), PULSE);
    end

    // R8: disarmed after firing
    curReq = "R8";
    wr(0, 0);
    idle(50, 1, 0);
    chk("R8 no refire", longint'(irqOut), 0);
    wr(0, 20);
    wr(12, 0);
    idle(12, 1, 0);
    chk("R8 rearm", longint'(irqOut), 1);
    idle(30, 1, 0);

    // R10: unmapped offsets
    curReq = "R10";
    wr(16, 32'hDEAD_BEEF);
    wr(2, 32'hDEAD_BEEF);
    wr(60, 32'hDEAD_BEEF);
    step(0, 0, 0, 16, 0);
    chk("R10 read", longint'(regRdata), 0);
    step(0, 0, 0, 9, 0);
    chk("R10 misaligned", longint'(regRdata), 0);
    step(0, 0, 0, 8, 0);
    chk("R10 cmp kept", longint'(regRdata), 30);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog act=timeout exp=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule